// File: doc/BRIEF.md
# Flash Erase Algorithm Sequencer

This block sits on the host side of a byte-wide flash device and erases the whole array without software stepping through the algorithm. After one `start` pulse it first has every byte written to 00h through a separate program-byte service. That service is reached by a request/acknowledge handshake. The block then applies erase pulses and checks the array byte by byte until every location reads back as FFh. The flash is driven through a simple one-cycle-per-phase command bus that has a write strobe, a read strobe, an address and a write data byte. Read data returns in the same cycle as the read strobe.

Each erase pulse is two back-to-back writes of the erase command. After the pulse the block waits a parameterised number of cycles. Each verify step writes the verify command together with the byte address, waits a shorter parameterised interval, and then reads that byte. A byte that is not FFh causes a new erase pulse. Verification then continues from the same address, not from zero. The number of erase pulses in one run is capped, and reaching the cap with a byte still unerased ends the run as a failure. A successful run finishes by writing the read-array command. The `done` and `pass` outputs then hold the outcome until the next start.

Top module: `fes_erase_seq`

## Requirements
- R1: After an accepted start, the block requests programming of every address from 0 up to `LAST_ADDR` in ascending order, one request at a time, with program data 00h. A request completes in a cycle where `pp_req` and `pp_ack` are both high. No erase or verify bus cycle occurs before the last byte has been programmed.
- R2: An erase pulse is a write of 20h in two consecutive cycles. The first pulse starts in the cycle after the last program handshake. The next bus cycle after a pulse is a verify write, and it comes exactly `ERASE_WAIT`+1 cycles after the second 20h write.
- R3: A verify step writes A0h with the byte address on `fl_addr`. It reads that same address exactly `VERIFY_WAIT`+1 cycles after the A0h write. A byte counts as erased only when the read data equals FFh.
- R4: Verification begins at address 0. After a byte reads FFh, the A0h write for the next address follows in the very next cycle.
- R5: When a verify read is not FFh and fewer than `PULSE_LIMIT` pulses have been applied in this run, a new erase pulse starts in the next cycle. Verification then resumes at the address that failed.
- R6: A run applies at most `PULSE_LIMIT` erase pulses. A failing read after the last allowed pulse ends the run with no further bus cycle. In the next cycle `done`=1, `pass`=0 and `busy`=0.
- R7: When the last address reads FFh, the block writes 00h in the next cycle. In the cycle after that, `done`=1, `pass`=1 and `busy`=0.
- R8: `busy` is high from the cycle after an accepted start until the run ends. A `start` while `busy` is high has no effect on the bus sequence.
- R9: `done` and `pass` keep their value after a run until the next accepted start. Both read 0 in the cycle after that start.
- R10: During and directly after reset, `busy`, `done`, `pass`, `fl_we`, `fl_re` and `pp_req` are all 0.
- R11: In any cycle, at most one of `fl_we`, `fl_re` and `pp_req` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an erase run (taken only while idle) |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The last run has finished; held until the next start |
| pass | output | 1 | The last run erased every byte; valid with `done` |
| fl_addr | output | ADDR_W | Flash command-bus address |
| fl_wdata | output | 8 | Flash command-bus write data |
| fl_we | output | 1 | Flash write cycle strobe |
| fl_re | output | 1 | Flash read cycle strobe |
| fl_rdata | input | 8 | Flash read data, valid in the `fl_re` cycle |
| pp_req | output | 1 | Program-byte request |
| pp_addr | output | ADDR_W | Address of the byte to program |
| pp_data | output | 8 | Data to program (always 00h) |
| pp_ack | input | 1 | Program-byte service accepts the request |

## Verification
The checker watches the local timing rules on every cycle. These are: erase writes come in pairs, the erase and verify wait gaps are exact, each read goes to the address of the last verify write, program addresses step in order, the pulse count stays within its cap, strobes are exclusive, and `done` is held. Only the bench's scenarios can show the whole ordering. That covers resumption at the failing address and not at zero, acceptance exactly at the pulse cap against failure one pulse beyond it, the closing read-command write, the pass/fail outcome, and stray starts having no effect. The bench shows these by running a flash model whose bytes need different numbers of pulses, and matching every bus event against a precomputed queue.

// File: rtl/fes_pkg.sv
package fes_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PREP,
        S_ERA1,
        S_ERA2,
        S_EWAIT,
        S_VCMD,
        S_VWAIT,
        S_VREAD,
        S_RDCMD
    } fes_state_e;

    localparam logic [7:0] CMD_ERASE   = 8'h20;
    localparam logic [7:0] CMD_EVERIFY = 8'hA0;
    localparam logic [7:0] CMD_READ    = 8'h00;
    localparam logic [7:0] BYTE_ERASED = 8'hFF;
    localparam logic [7:0] BYTE_ZERO   = 8'h00;

    // One flash bus phase as driven by the sequencer
    typedef struct packed {
        logic       wr;
        logic       rd;
        logic [7:0] data;
    } fes_cycle_t;

    function automatic logic is_erased(input logic [7:0] b);
        return b == BYTE_ERASED;
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fes_step_ctr.sv
module fes_step_ctr #(
    parameter int W   = 8,
    parameter int MAX = 255
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q,
    output logic         at_max
);
    localparam logic [W-1:0] MAX_Q = W'(MAX);

    always_ff @(posedge clk) begin
        if (rst || clr)
            q <= '0;
        else if (inc)
            q <= q + 1'b1;
    end

    assign at_max = (q == MAX_Q);
endmodule

// File: rtl/fes_wait_timer.sv
module fes_wait_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expire
);
    logic [TW-1:0] cnt;

    // Loaded with N on entry to a wait state; expire marks the N-th cycle
    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expire = (cnt == TW'(1));
endmodule

// File: rtl/fes_seq_fsm.sv
module fes_seq_fsm
    import fes_pkg::*;
#(
    parameter int TW          = 8,
    parameter int ERASE_WAIT  = 16,
    parameter int VERIFY_WAIT = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          prog_ack,
    input  logic [7:0]    rd_data,
    input  logic          addr_last,
    input  logic          pulse_at_limit,
    input  logic          tmr_expire,
    output logic          addr_clr,
    output logic          addr_inc,
    output logic          pulse_clr,
    output logic          pulse_inc,
    output logic          tmr_load,
    output logic [TW-1:0] tmr_val,
    output fes_cycle_t    cyc,
    output logic          prog_req,
    output logic          busy,
    output logic          done,
    output logic          pass
);
    localparam logic [TW-1:0] ERASE_T  = TW'(ERASE_WAIT);
    localparam logic [TW-1:0] VERIFY_T = TW'(VERIFY_WAIT);

    fes_state_e state, nxt;
    logic       fin, fin_pass;

    always_comb begin
        nxt       = state;
        addr_clr  = 1'b0;
        addr_inc  = 1'b0;
        pulse_clr = 1'b0;
        pulse_inc = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = ERASE_T;
        cyc       = '{wr: 1'b0, rd: 1'b0, data: CMD_READ};
        prog_req  = 1'b0;
        fin       = 1'b0;
        fin_pass  = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (start) begin
                    addr_clr  = 1'b1;
                    pulse_clr = 1'b1;
                    nxt       = S_PREP;
                end
            end
            S_PREP: begin
                prog_req = 1'b1;
                if (prog_ack) begin
                    if (addr_last) begin
                        addr_clr = 1'b1;
                        nxt      = S_ERA1;
                    end else begin
                        addr_inc = 1'b1;
                    end
                end
            end
            S_ERA1: begin
                cyc = '{wr: 1'b1, rd: 1'b0, data: CMD_ERASE};
                nxt = S_ERA2;
            end
            S_ERA2: begin
                cyc       = '{wr: 1'b1, rd: 1'b0, data: CMD_ERASE};
                pulse_inc = 1'b1;
                tmr_load  = 1'b1;
                tmr_val   = ERASE_T;
                nxt       = S_EWAIT;
            end
            S_EWAIT: begin
                if (tmr_expire)
                    nxt = S_VCMD;
            end
            S_VCMD: begin
                cyc      = '{wr: 1'b1, rd: 1'b0, data: CMD_EVERIFY};
                tmr_load = 1'b1;
                tmr_val  = VERIFY_T;
                nxt      = S_VWAIT;
            end
            S_VWAIT: begin
                if (tmr_expire)
                    nxt = S_VREAD;
            end
            S_VREAD: begin
                cyc = '{wr: 1'b0, rd: 1'b1, data: CMD_READ};
                if (is_erased(rd_data)) begin
                    if (addr_last) begin
                        nxt = S_RDCMD;
                    end else begin
                        addr_inc = 1'b1;
                        nxt      = S_VCMD;
                    end
                end else if (pulse_at_limit) begin
                    fin      = 1'b1;
                    fin_pass = 1'b0;
                    nxt      = S_IDLE;
                end else begin
                    nxt = S_ERA1;   // address kept: resume here after the pulse
                end
            end
            S_RDCMD: begin
                cyc      = '{wr: 1'b1, rd: 1'b0, data: CMD_READ};
                fin      = 1'b1;
                fin_pass = 1'b1;
                nxt      = S_IDLE;
            end
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            done  <= 1'b0;
            pass  <= 1'b0;
        end else begin
            state <= nxt;
            if (state == S_IDLE && start) begin
                done <= 1'b0;
                pass <= 1'b0;
            end else if (fin) begin
                done <= 1'b1;
                pass <= fin_pass;
            end
        end
    end

    assign busy = (state != S_IDLE);
endmodule

// File: rtl/fes_erase_seq.sv
module fes_erase_seq
    import fes_pkg::*;
#(
    parameter int ADDR_W      = 17,
    parameter int LAST_ADDR   = 131071,
    parameter int ERASE_WAIT  = 2000000,
    parameter int VERIFY_WAIT = 1200,
    parameter int PULSE_LIMIT = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              pass,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [7:0]        fl_wdata,
    output logic              fl_we,
    output logic              fl_re,
    input  logic [7:0]        fl_rdata,
    output logic              pp_req,
    output logic [ADDR_W-1:0] pp_addr,
    output logic [7:0]        pp_data,
    input  logic              pp_ack
);
    localparam int TW = $clog2(max_of(ERASE_WAIT, VERIFY_WAIT) + 1);
    localparam int PW = $clog2(PULSE_LIMIT + 1);

    logic              addr_clr, addr_inc, addr_last;
    logic              pulse_clr, pulse_inc, pulse_at_limit;
    logic              tmr_load, tmr_expire;
    logic [TW-1:0]     tmr_val;
    logic [ADDR_W-1:0] addr_q;
    logic [PW-1:0]     pulse_q;
    fes_cycle_t        cyc;

    // Shared byte pointer: preprogram address, then verify address
    fes_step_ctr #(.W(ADDR_W), .MAX(LAST_ADDR)) u_addr (
        .clk(clk), .rst(rst), .clr(addr_clr), .inc(addr_inc),
        .q(addr_q), .at_max(addr_last)
    );

    fes_step_ctr #(.W(PW), .MAX(PULSE_LIMIT)) u_pulse (
        .clk(clk), .rst(rst), .clr(pulse_clr), .inc(pulse_inc),
        .q(pulse_q), .at_max(pulse_at_limit)
    );

    fes_wait_timer #(.TW(TW)) u_tmr (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val),
        .expire(tmr_expire)
    );

    fes_seq_fsm #(.TW(TW), .ERASE_WAIT(ERASE_WAIT), .VERIFY_WAIT(VERIFY_WAIT)) u_fsm (
        .clk(clk), .rst(rst), .start(start), .prog_ack(pp_ack),
        .rd_data(fl_rdata), .addr_last(addr_last),
        .pulse_at_limit(pulse_at_limit), .tmr_expire(tmr_expire),
        .addr_clr(addr_clr), .addr_inc(addr_inc),
        .pulse_clr(pulse_clr), .pulse_inc(pulse_inc),
        .tmr_load(tmr_load), .tmr_val(tmr_val), .cyc(cyc),
        .prog_req(pp_req), .busy(busy), .done(done), .pass(pass)
    );

    logic unused_pulse;
    assign unused_pulse = ^pulse_q;

    assign fl_addr  = addr_q;
    assign fl_wdata = cyc.data;
    assign fl_we    = cyc.wr;
    assign fl_re    = cyc.rd;
    assign pp_addr  = addr_q;
    assign pp_data  = BYTE_ZERO;
endmodule

// File: rtl/fes_erase_seq_chk.sv
module fes_erase_seq_chk
    import fes_pkg::*;
#(
    parameter int ADDR_W      = 17,
    parameter int ERASE_WAIT  = 2000000,
    parameter int VERIFY_WAIT = 1200,
    parameter int PULSE_LIMIT = 1000
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              pass,
    input logic [ADDR_W-1:0] fl_addr,
    input logic [7:0]        fl_wdata,
    input logic              fl_we,
    input logic              fl_re,
    input logic              pp_req,
    input logic [ADDR_W-1:0] pp_addr,
    input logic              pp_ack
);
    logic [31:0]       since_wr;
    logic [7:0]        last_wdata;
    logic [ADDR_W-1:0] vfy_addr;
    logic              era_odd;
    logic [31:0]       era_writes;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_wr   <= 32'd0;
            last_wdata <= 8'h00;
            vfy_addr   <= '0;
            era_odd    <= 1'b0;
            era_writes <= 32'd0;
        end else begin
            if (fl_we) begin
                since_wr   <= 32'd1;
                last_wdata <= fl_wdata;
            end else if (since_wr != 32'hFFFF_FFFF) begin
                since_wr <= since_wr + 32'd1;
            end
            if (fl_we && fl_wdata == CMD_EVERIFY)
                vfy_addr <= fl_addr;
            if (fl_we && fl_wdata == CMD_ERASE)
                era_odd <= ~era_odd;
            if (start && !busy)
                era_writes <= 32'd0;
            else if (fl_we && fl_wdata == CMD_ERASE)
                era_writes <= era_writes + 32'd1;
        end
    end

    // R11
    a_r11_one_strobe: assert property (@(posedge clk) disable iff (rst)
        !(fl_we && fl_re) && !(pp_req && (fl_we || fl_re)));

    // R1
    a_r1_prog_ascending: assert property (@(posedge clk) disable iff (rst)
        pp_req && $past(pp_req && pp_ack) |-> pp_addr == $past(pp_addr) + 1'b1);

    // R2
    a_r2_erase_pair: assert property (@(posedge clk) disable iff (rst)
        fl_we && fl_wdata == CMD_ERASE && !era_odd |=> fl_we && fl_wdata == CMD_ERASE);

    // R2
    a_r2_erase_wait: assert property (@(posedge clk) disable iff (rst)
        fl_we && fl_wdata == CMD_EVERIFY && last_wdata == CMD_ERASE
        |-> since_wr == 32'(ERASE_WAIT + 1));

    // R3
    a_r3_verify_read: assert property (@(posedge clk) disable iff (rst)
        fl_re |-> last_wdata == CMD_EVERIFY && fl_addr == vfy_addr
                  && since_wr == 32'(VERIFY_WAIT + 1));

    // R6
    a_r6_pulse_cap: assert property (@(posedge clk) disable iff (rst)
        era_writes <= 32'(2 * PULSE_LIMIT));

    // R8
    a_r8_busy_not_done: assert property (@(posedge clk) disable iff (rst)
        busy |-> !done);

    // R9
    a_r9_done_held: assert property (@(posedge clk) disable iff (rst)
        done && !start |=> done && $stable(pass));

    // R7
    a_r7_pass_with_done: assert property (@(posedge clk) disable iff (rst)
        pass |-> done);
endmodule

bind fes_erase_seq fes_erase_seq_chk #(
    .ADDR_W(ADDR_W), .ERASE_WAIT(ERASE_WAIT),
    .VERIFY_WAIT(VERIFY_WAIT), .PULSE_LIMIT(PULSE_LIMIT)
) u_chk (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .pass(pass),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_we(fl_we), .fl_re(fl_re),
    .pp_req(pp_req), .pp_addr(pp_addr), .pp_ack(pp_ack)
);

// File: tb/sim_fes_erase_seq.sv
`timescale 1ns/1ps
module sim_fes_erase_seq;
    localparam int AW = 4, LAST = 11, EW = 5, VW = 3, LIM = 4;
    localparam int K_PROG = 0, K_WR = 1, K_RD = 2;
    localparam int WATCHDOG = 150000;

    logic clk = 1'b0, rst = 1'b1;
    logic start_main = 1'b0, start_noise = 1'b0;
    logic start;
    logic busy, done, pass, fl_we, fl_re, pp_req, pp_ack = 1'b0;
    logic [AW-1:0] fl_addr, pp_addr;
    logic [7:0] fl_wdata, fl_rdata, pp_data;

    int need [0:15];
    int erase_wr_seen = 0;
    int n_cmp = 0, n_bad = 0, cyc = 0, last_evt_cyc = 0, done_cyc = 0, evts = 0;
    int ack_period = 1, ack_phase = 0;
    bit noise_en = 0, done_q = 0, exp_pass = 0;
    int q_kind[$], q_addr[$], q_data[$], q_gap[$];

    always #2.5 clk = ~clk;
    assign start = start_main | start_noise;
    // Flash model: a byte reads FFh once enough erase pulses have been applied
    assign fl_rdata = (int'(fl_addr) <= LAST && (erase_wr_seen / 2) >= need[fl_addr]) ? 8'hFF : 8'h00;

    fes_erase_seq #(.ADDR_W(AW), .LAST_ADDR(LAST), .ERASE_WAIT(EW),
                    .VERIFY_WAIT(VW), .PULSE_LIMIT(LIM)) u0 (
        .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .pass(pass),
        .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_we(fl_we), .fl_re(fl_re),
        .fl_rdata(fl_rdata), .pp_req(pp_req), .pp_addr(pp_addr), .pp_data(pp_data),
        .pp_ack(pp_ack)
    );

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic string tag_for(int k, int d);
        if (k == K_PROG) return "R1";
        if (k == K_RD) return "R3";
        if (d == 32'h20) return "R2";
        if (d == 32'hA0) return "R4/R5";
        return "R7";
    endfunction

    task automatic push(int k, int a, int d, int g);
        q_kind.push_back(k); q_addr.push_back(a); q_data.push_back(d); q_gap.push_back(g);
    endtask

    task automatic take_event(int k, int a, int d);
        int ek, ea, ed, eg;
        string t;
        if (q_kind.size() == 0) begin
            chk(0, "R8", "unexpected bus event kind", k, -1);
        end else begin
            ek = q_kind.pop_front(); ea = q_addr.pop_front();
            ed = q_data.pop_front(); eg = q_gap.pop_front();
            t = tag_for(ek, ed);
            chk(k == ek, t, "event kind", k, ek);
            if (ea >= 0) chk(a == ea, t, "event address", a, ea);
            if (ek != K_RD) chk(d == ed, t, "event data", d, ed);
            if (eg >= 0) chk(cyc - last_evt_cyc == eg, t, "cycle gap", cyc - last_evt_cyc, eg);
        end
        last_evt_cyc = cyc;
    endtask

    // Expected bus event list worked out from the requirements
    task automatic build_expect();
        int p, v, g;
        bit fin;
        q_kind.delete(); q_addr.delete(); q_data.delete(); q_gap.delete();
        for (int a = 0; a <= LAST; a++) push(K_PROG, a, 0, -1);
        p = 0; v = 0; g = 1; fin = 0;
        while (!fin) begin
            push(K_WR, -1, 32'h20, g);
            push(K_WR, -1, 32'h20, 1);
            p++;
            g = EW + 1;
            while (1) begin
                push(K_WR, v, 32'hA0, g);
                push(K_RD, v, 0, VW + 1);
                if (p >= need[v]) begin
                    if (v == LAST) begin
                        push(K_WR, -1, 0, 1);
                        exp_pass = 1; fin = 1; break;
                    end
                    v++; g = 1;
                end else if (p >= LIM) begin
                    exp_pass = 0; fin = 1; break;
                end else begin
                    g = 1; break;
                end
            end
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Per-clock monitor: acknowledges programming, logs and matches bus events
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (cyc > WATCHDOG) begin
                chk(0, "R8", "watchdog expired at cycle", cyc, WATCHDOG);
                summary();
                $finish;
            end
            if (rst) begin
                pp_ack = 1'b0;
                start_noise = 1'b0;
            end else begin
                if (pp_req) begin
                    pp_ack = ((ack_phase % ack_period) == ack_period - 1);
                    ack_phase++;
                end else begin
                    pp_ack = 1'b0;
                end
                evts = 0;
                if (pp_req && pp_ack) begin
                    evts++;
                    take_event(K_PROG, int'(pp_addr), int'(pp_data));
                end
                if (fl_we) begin
                    evts++;
                    take_event(K_WR, int'(fl_addr), int'(fl_wdata));
                    if (fl_wdata == 8'h20) erase_wr_seen++;
                end
                if (fl_re) begin
                    evts++;
                    take_event(K_RD, int'(fl_addr), 0);
                end
                if (evts > 1) chk(0, "R11", "strobes in one cycle", evts, 1);
                if (done && !done_q) done_cyc = cyc;
                done_q = done;
                start_noise = noise_en && busy && (cyc % 5 == 0);
            end
        end
    end

    task automatic run_case(int period, bit noise, bit had_prev);
        int guard;
        ack_period = period;
        ack_phase = 0;
        erase_wr_seen = 0;
        build_expect();
        @(negedge clk);
        start_main = 1'b1;
        @(negedge clk);
        start_main = 1'b0;
        chk(busy == 1'b1, "R8", "busy after start", busy, 1);
        if (had_prev) begin
            chk(done == 1'b0, "R9", "done cleared by start", done, 0);
            chk(pass == 1'b0, "R9", "pass cleared by start", pass, 0);
        end
        noise_en = noise;
        guard = 0;
        while (!done && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        noise_en = 1'b0;
        chk(q_kind.size() == 0, exp_pass ? "R7" : "R6", "events left unseen", q_kind.size(), 0);
        chk(done_cyc == last_evt_cyc + 1, exp_pass ? "R7" : "R6", "done cycle", done_cyc, last_evt_cyc + 1);
        chk(pass == exp_pass, exp_pass ? "R7" : "R6", "pass result", pass, exp_pass);
        chk(busy == 1'b0, "R8", "busy after finish", busy, 0);
        if (noise) chk(q_kind.size() == 0, "R8", "stray start left sequence intact", q_kind.size(), 0);
        repeat (4) @(negedge clk);
        chk(done == 1'b1, "R9", "done held", done, 1);
        chk(pass == exp_pass, "R9", "pass held", pass, exp_pass);
    endtask

    initial begin
        for (int a = 0; a < 16; a++) need[a] = 1;
        repeat (3) @(negedge clk);
        chk(busy == 0 && done == 0 && pass == 0, "R10", "status in reset", {busy, done, pass}, 0);
        chk(fl_we == 0 && fl_re == 0 && pp_req == 0, "R10", "strobes in reset", {fl_we, fl_re, pp_req}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 0 && done == 0 && pass == 0, "R10", "status after reset", {busy, done, pass}, 0);
        chk(fl_we == 0 && fl_re == 0 && pp_req == 0, "R10", "strobes after reset", {fl_we, fl_re, pp_req}, 0);

        // R1 R2 R3 R4 R7: every byte erased by the first pulse
        run_case(1, 0, 0);

        // R5: bytes 3 and 7 need extra pulses; verify resumes at them
        for (int a = 0; a < 16; a++) need[a] = 1;
        need[3] = 2; need[7] = 3;
        run_case(2, 0, 1);

        // R6 boundary: a byte needs exactly the cap and still passes
        for (int a = 0; a < 16; a++) need[a] = 1;
        need[LAST] = LIM;
        run_case(3, 0, 1);

        // R6: one byte needs one pulse more than the cap
        for (int a = 0; a < 16; a++) need[a] = 1;
        need[0] = LIM + 1;
        run_case(1, 0, 1);

        // R8: stray starts while busy, with a byte that fails twice
        for (int a = 0; a < 16; a++) need[a] = 1;
        need[5] = 3;
        run_case(2, 1, 1);

        summary();
        $finish;
    end
endmodule